// File: doc/BRIEF.md
# Buffered Serial Frame Transmitter

This block serialises characters onto a single line, one bit per strobe from an external bit-rate generator. A one-entry holding buffer sits in front of the shift stage. Software or a producer can therefore queue the next character while the current one is still on the wire. When a frame ends and the buffer holds a word, the next frame starts on the very next bit period, with no idle gap.

The frame format is chosen by three plain control inputs and is sampled when a word moves into the shift stage:
- a character size of 5 to 9 bits;
- a parity option of none, even or odd;
- one or two stop bits.

A producer writes through a valid/ready handshake. Status flags and two masked interrupt requests report buffer-empty and transmission-complete. Dropping the enable input only stops the block once every queued bit has been sent. After that the line is released and rests high.

The write port follows valid/ready rules. A word is accepted on a clock edge where both `wr_valid` and `wr_ready` are high. `wr_ready` is high only while the buffer is empty and the transmitter is enabled. A producer that holds `wr_valid` while `wr_ready` is low is stalled, and nothing is taken. The producer does not have to hold its data stable while it is stalled.

Top module: `stx_frame_tx`

## Requirements
- R1: A frame is sent as a low start bit, then the character bits least significant first, then the optional parity bit, then the stop bits (high). Between frames, and while no frame is active, `txd` is high.
- R2: `data_sel` selects the character size: 3'd0=5, 3'd1=6, 3'd2=7, 3'd3=8, and any value with bit 2 set selects 9 bits. For sizes below 8, the unused upper bits of `wr_data` are ignored. The ninth bit is `wr_bit8` as captured at the handshake; later changes to `wr_bit8` do not affect the queued word.
- R3: `par_mode` 2'b10 appends even parity (the XOR of the character bits). 2'b11 appends odd parity (that XOR, inverted). 2'b00 and 2'b01 append no parity bit. The parity bit follows the last character bit.
- R4: `two_stop`=0 gives one stop bit and `two_stop`=1 gives two.
- R5: `buf_empty` is 1 after reset and goes to 0 on the edge that accepts a write. `wr_ready` is high only while `buf_empty`=1 and `tx_en`=1. A write attempt while `wr_ready` is low changes neither the buffer nor the frame that is later sent.
- R6: A buffered word moves into the shift stage on a `bit_tick` when the shift stage is idle. It also moves in on the tick that ends the previous frame's last stop bit, so the new start bit follows at once. `buf_empty` returns to 1 on that same edge.
- R7: `tx_done` sets on the tick that ends a frame while the buffer is empty. It clears on a cycle with `txc_clr`=1 or `irq_ack`=1, unless it is being set in that same cycle. It is 0 after reset.
- R8: With `tx_en`=0, `tx_drive` stays 1 while the buffer or the shift stage holds data. It falls only after both are empty. While `tx_drive`=0, `txd` is 1.
- R9: `irq_empty` = `buf_empty` AND `empty_ie`, and `irq_done` = `tx_done` AND `done_ie`.
- R10: `txd` changes only on a clock edge where `bit_tick` is 1. Each bit lasts from one tick to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| data_sel | input | 3 | Character size select (R2) |
| par_mode | input | 2 | Parity select (R3) |
| two_stop | input | 1 | Two stop bits when 1 |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_data | input | 8 | Low character bits |
| wr_bit8 | input | 1 | Ninth character bit |
| txc_clr | input | 1 | Write-one clear of tx_done |
| irq_ack | input | 1 | Complete-interrupt acknowledge, clears tx_done |
| empty_ie | input | 1 | Buffer-empty interrupt mask |
| done_ie | input | 1 | Complete interrupt mask |
| txd | output | 1 | Serial data line |
| tx_drive | output | 1 | High while the block owns the line |
| buf_empty | output | 1 | Holding buffer empty flag |
| tx_done | output | 1 | Transmission complete flag |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | Complete interrupt request |

## Verification
A wrong internal state shows up on `txd` or on one of the flags no later than the next bit tick.

- **Bit counter or shift register wrong.** The line takes a wrong value at a specific bit position of the frame, within that tick.
- **Buffer occupancy wrong.** Either a start bit appears that should not, or one is missing, on the tick that closes a frame. `buf_empty` and `wr_ready` are also wrong from the very next clock.
- **Complete flag or enable release wrong.** `tx_done` or `tx_drive` fails to change on the frame-ending tick. It is observed one half cycle after that edge.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int LOW_W   = 8;
  localparam int CHAR_W  = LOW_W + 1;
  localparam int MAX_STOP = 2;
  localparam int FRAME_W = 1 + CHAR_W + 1 + MAX_STOP;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [2:0] size;
    logic [1:0] par;
    logic       two;
  } stx_fmt_t;

  function automatic int char_len(input logic [2:0] size);
    if (size[2]) return CHAR_W;
    return 5 + int'(size[1:0]);
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(input stx_fmt_t f);
    int n;
    n = 1 + char_len(f.size) + (f.par[1] ? 1 : 0) + (f.two ? 2 : 1);
    return CNT_W'(n);
  endfunction

  // Bit 0 is sent first; unused positions stay 1 and serve as stop bits.
  function automatic logic [FRAME_W-1:0] frame_bits(input logic [CHAR_W-1:0] d,
                                                    input stx_fmt_t f);
    logic [FRAME_W-1:0] v;
    logic p;
    int n;
    n = char_len(f.size);
    v = '1;
    v[0] = 1'b0;
    p = f.par[0];
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < n) begin
        v[1+i] = d[i];
        p = p ^ d[i];
      end
    end
    if (f.par[1]) v[1+n] = p;
    return v;
  endfunction
endpackage

// File: rtl/stx_hold_buf.sv
module stx_hold_buf
  import stx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              wr_valid,
  input  logic [LOW_W-1:0]  wr_data,
  input  logic              wr_bit8,
  input  logic              pop,
  output logic              wr_ready,
  output logic              full,
  output logic [CHAR_W-1:0] word
);
  logic push;

  assign wr_ready = !full && tx_en;
  assign push     = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else if (push) begin
      full <= 1'b1;
      word <= {wr_bit8, wr_data};
    end else if (pop) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
  import stx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              buf_full,
  input  logic [CHAR_W-1:0] buf_word,
  input  stx_fmt_t          fmt,
  output logic              load,
  output logic              frame_end,
  output logic              busy,
  output logic              txd
);
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   rem;
  logic [FRAME_W-1:0] fb;
  logic               last;

  assign fb        = frame_bits(buf_word, fmt);
  assign last      = busy && (rem == '0);
  assign load      = bit_tick && buf_full && (!busy || last);
  assign frame_end = bit_tick && last && !buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      rem  <= '0;
      txd  <= 1'b1;
    end else if (load) begin
      busy <= 1'b1;
      txd  <= fb[0];
      sh   <= {1'b1, fb[FRAME_W-1:1]};
      rem  <= frame_len(fmt) - CNT_W'(1);
    end else if (bit_tick && busy) begin
      if (rem != '0) begin
        txd <= sh[0];
        sh  <= {1'b1, sh[FRAME_W-1:1]};
        rem <= rem - CNT_W'(1);
      end else begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/stx_status.sv
module stx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic busy,
  input  logic buf_full,
  input  logic frame_end,
  input  logic txc_clr,
  input  logic irq_ack,
  input  logic empty_ie,
  input  logic done_ie,
  output logic tx_drive,
  output logic tx_done,
  output logic irq_empty,
  output logic irq_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tx_done <= 1'b0;
    else if (frame_end)         tx_done <= 1'b1;
    else if (txc_clr || irq_ack) tx_done <= 1'b0;
  end

  assign tx_drive  = tx_en || busy || buf_full;
  assign irq_empty = !buf_full && empty_ie;
  assign irq_done  = tx_done && done_ie;
endmodule

// File: rtl/stx_frame_tx.sv
module stx_frame_tx
  import stx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [2:0]       data_sel,
  input  logic [1:0]       par_mode,
  input  logic             two_stop,
  input  logic             bit_tick,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [LOW_W-1:0] wr_data,
  input  logic             wr_bit8,
  input  logic             txc_clr,
  input  logic             irq_ack,
  input  logic             empty_ie,
  input  logic             done_ie,
  output logic             txd,
  output logic             tx_drive,
  output logic             buf_empty,
  output logic             tx_done,
  output logic             irq_empty,
  output logic             irq_done
);
  logic              full, load, frame_end, busy, sh_txd;
  logic [CHAR_W-1:0] word;
  stx_fmt_t          fmt;

  assign fmt = '{size: data_sel, par: par_mode, two: two_stop};

  stx_hold_buf u_buf (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_bit8(wr_bit8), .pop(load),
    .wr_ready(wr_ready), .full(full), .word(word)
  );

  stx_shifter u_sh (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .buf_full(full),
    .buf_word(word), .fmt(fmt), .load(load), .frame_end(frame_end),
    .busy(busy), .txd(sh_txd)
  );

  stx_status u_st (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .busy(busy), .buf_full(full),
    .frame_end(frame_end), .txc_clr(txc_clr), .irq_ack(irq_ack),
    .empty_ie(empty_ie), .done_ie(done_ie), .tx_drive(tx_drive),
    .tx_done(tx_done), .irq_empty(irq_empty), .irq_done(irq_done)
  );

  assign buf_empty = !full;
  assign txd       = tx_drive ? sh_txd : 1'b1;
endmodule

// File: rtl/stx_frame_tx_chk.sv
module stx_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic bit_tick,
  input logic wr_valid,
  input logic wr_ready,
  input logic txc_clr,
  input logic irq_ack,
  input logic empty_ie,
  input logic done_ie,
  input logic txd,
  input logic tx_drive,
  input logic buf_empty,
  input logic tx_done,
  input logic irq_empty,
  input logic irq_done
);
  p_write_takes_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !buf_empty);
  p_ready_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (tx_en && buf_empty));
  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (txc_clr || irq_ack) && !bit_tick |=> !tx_done);
  p_released_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_drive |-> txd);
  p_release_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_drive) |-> (buf_empty && !tx_en));
  p_irq_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |-> (buf_empty && empty_ie));
  p_irq_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (tx_done && done_ie));
  p_txd_steps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick && tx_en |=> $stable(txd));
endmodule

bind stx_frame_tx stx_frame_tx_chk u_chk (.*);

// File: tb/tb_stx_frame_tx.sv
module tb_stx_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {char[8:0], size[2:0], par[1:0], two}
  localparam logic [14:0] VECS [NVEC] = '{
    {9'h0A5, 3'd3, 2'b00, 1'b0},
    {9'h0FF, 3'd0, 2'b10, 1'b0},
    {9'h13C, 3'd4, 2'b11, 1'b1},
    {9'h055, 3'd2, 2'b10, 1'b1},
    {9'h0E3, 3'd1, 2'b11, 1'b0},
    {9'h1FF, 3'd4, 2'b00, 1'b0},
    {9'h000, 3'd3, 2'b11, 1'b1},
    {9'h0C8, 3'd2, 2'b01, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic tx_en = 0, two_stop = 0, bit_tick = 0, wr_valid = 0, wr_bit8 = 0;
  logic txc_clr = 0, irq_ack = 0, empty_ie = 0, done_ie = 0;
  logic [2:0] data_sel = 3'd3;
  logic [1:0] par_mode = 2'b00;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready, txd, tx_drive, buf_empty, tx_done, irq_empty, irq_done;
  int checks = 0, fails = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stx_frame_tx dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); bit_tick = 1;
    @(negedge clk); bit_tick = 0;
  endtask

  task automatic put(logic [8:0] c);
    @(negedge clk); wr_valid = 1; wr_data = c[7:0]; wr_bit8 = c[8];
    @(negedge clk); wr_valid = 0;
  endtask

  function automatic int nchar(logic [2:0] s);
    return s[2] ? 9 : 5 + s[1:0];
  endfunction

  function automatic int flen(logic [2:0] s, logic [1:0] p, logic t);
    return 1 + nchar(s) + p[1] + 1 + t;
  endfunction

  function automatic logic exp_bit(logic [8:0] c, logic [2:0] s, logic [1:0] p, int k);
    int n = nchar(s);
    logic par = p[0];
    for (int i = 0; i < n; i++) par ^= c[i];
    if (k == 0) return 1'b0;
    if (k <= n) return c[k-1];
    if (k == n + 1 && p[1]) return par;
    return 1'b1;
  endfunction

  // Sends bits of a frame already loaded; start bit is already on the line at index 0.
  task automatic follow(string req, logic [8:0] c, logic [2:0] s, logic [1:0] p, logic t);
    int L = flen(s, p, t);
    chk(req, txd, exp_bit(c, s, p, 0));
    for (int k = 1; k < L; k++) begin
      tick();
      chk(req, txd, exp_bit(c, s, p, k));
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done_flag && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done_flag) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5 R7 R1 reset state
    chk("R5 reset buf_empty", buf_empty, 1);
    chk("R7 reset tx_done", tx_done, 0);
    chk("R1 reset txd", txd, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R5 ready off when disabled", wr_ready, 0);
    tx_en = 1;

    // Table walk: R1 R2 R3 R4 R7
    for (int v = 0; v < NVEC; v++) begin
      logic [8:0] c; logic [2:0] s; logic [1:0] p; logic t;
      {c, s, p, t} = VECS[v];
      data_sel = s; par_mode = p; two_stop = t;
      @(negedge clk); txc_clr = 1; @(negedge clk); txc_clr = 0;
      put(c);
      chk("R5 write clears empty", buf_empty, 0);
      tick();
      chk("R6 load empties buffer", buf_empty, 1);
      follow("R1 R2 R3 R4 frame", c, s, p, t);
      chk("R7 not done mid frame", tx_done, 0);
      tick();
      chk("R1 idle high after frame", txd, 1);
      chk("R7 done set", tx_done, 1);
    end

    // R10 txd holds without tick
    data_sel = 3'd3; par_mode = 2'b00; two_stop = 0;
    put(9'h001); tick();
    chk("R10 start bit", txd, 0);
    repeat (5) @(negedge clk);
    chk("R10 held without tick", txd, 0);
    follow("R10 frame", 9'h001, 3'd3, 2'b00, 0);
    tick();

    // R6 back-to-back
    @(negedge clk); txc_clr = 1; @(negedge clk); txc_clr = 0;
    put(9'h03C); tick();
    put(9'h0C3);
    follow("R6 first", 9'h03C, 3'd3, 2'b00, 0);
    tick();
    chk("R6 no gap start bit", txd, 0);
    chk("R7 no done between frames", tx_done, 0);
    follow("R6 second", 9'h0C3, 3'd3, 2'b00, 0);
    tick();
    chk("R7 done after pair", tx_done, 1);

    // R7 clear paths
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk("R7 ack clears", tx_done, 0);

    // R5 ignored write while full; R2 ninth bit latched at handshake
    data_sel = 3'd4;
    put(9'h15A);
    @(negedge clk); wr_valid = 1; wr_data = 8'hFF; wr_bit8 = 0;
    @(negedge clk); wr_valid = 0;
    tick();
    follow("R5 R2 ignored write, latched bit8", 9'h15A, 3'd4, 2'b00, 0);
    tick();

    // R9 interrupts
    empty_ie = 1; done_ie = 1;
    @(negedge clk);
    chk("R9 irq_empty", irq_empty, 1);
    chk("R9 irq_done", irq_done, 1);
    @(negedge clk); txc_clr = 1; @(negedge clk); txc_clr = 0;
    chk("R9 irq_done drops", irq_done, 0);
    put(9'h011);
    chk("R9 irq_empty drops", irq_empty, 0);
    empty_ie = 0; done_ie = 0;

    // R8 deferred disable
    data_sel = 3'd3;
    tx_en = 0;
    @(negedge clk);
    chk("R8 drive held with buffered word", tx_drive, 1);
    tick();
    follow("R8 frame after disable", 9'h011, 3'd3, 2'b00, 0);
    chk("R8 drive during frame", tx_drive, 1);
    tick();
    chk("R8 released", tx_drive, 0);
    chk("R8 released line high", txd, 1);

    // R5 write while disabled ignored
    put(9'h000);
    chk("R5 disabled write ignored", buf_empty, 1);
    tick(); tick();
    chk("R5 no frame from ignored write", txd, 1);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule